// File: doc/BRIEF.md
# Bit-Slip Word Realignment Deserializer

This block turns a serial bit stream, arriving one bit per cycle of a fast clock, into parallel words of 4 to 10 bits. A parallel clock enable, produced inside the block, marks each new word. The first bit received for a word ends up in the highest active bit of the word. The unused high bits of the 10-bit output are zero.

Core logic moves the word boundary by pulsing a slip request. The block samples this request once per parallel period and detects its rising edge there. Each detected edge adds one bit time of delay to the serial stream, so every later word starts one bit earlier in the source stream. The number of slips before the delay wraps back to zero is configurable from 1 to 11, independent of the word width. When the wrap happens, a rollover flag is raised for one parallel period.

The word presented just after a slip is marked not valid, because the block treats it as part of the settling window. The word presented two parallel periods after the slip edge is valid again. The word width and the rollover point are static settings that are held while the block runs.

Top module: `bitslip_deser`

## Requirements
- R1: `par_tick` is high for exactly one fast-clock cycle in every `cfg_width` cycles. Its first high cycle comes right after the `cfg_width`-th rising edge following the release of reset. `par_word`, `par_valid` and `roll_flag` change only together with it.
- R2: With zero slips, word n (counting from 1 after reset) holds serial bits (n-1)*W through n*W-1, where W is the word width. The earliest bit is at bit W-1 and the latest at bit 0, and bits W and above are 0.
- R3: With a current delay of d bit times, word n holds serial bits (n-1)*W-d through n*W-1-d, in the same order as in R2. Bits taken from before reset read as 0.
- R4: `slip_req` is sampled only at the rising edge that completes a word. A slip is counted when it is high at one such edge and was low at the previous one. A level held high over several words counts once, and high pulses that end before a word boundary have no effect.
- R5: Each counted slip raises the delay by one bit for all words completed after the sampling edge. When the raised count would equal `cfg_roll`, the delay returns to 0 instead. In that case `roll_flag` is 1 for the word completed at that same edge, and 0 for every other word.
- R6: `par_valid` is 0 for the word that follows a word whose edge counted a slip. It is 1 for every other word.
- R7: While reset is high, all outputs are 0, the delay is 0 and the word phase restarts. This holds whatever delay was in use before reset.
- R8: R1 to R6 hold for every combination of width 4 to 10 and rollover point 1 to 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast serial bit clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_in | input | 1 | Serial data, one bit per clock |
| slip_req | input | 1 | Word-boundary slip request, sampled once per word |
| cfg_width | input | 4 | Word width, 4 to 10 (values outside are clamped) |
| cfg_roll | input | 4 | Slips before the delay wraps, 1 to 11 (values outside are clamped) |
| par_word | output | 10 | Parallel word, earliest bit at bit width-1 |
| par_tick | output | 1 | One-cycle parallel enable marking a new word |
| par_valid | output | 1 | Word is outside the slip settling window |
| roll_flag | output | 1 | Delay wrapped to zero at this word's boundary |

## Verification
A wrong delay count shows up as a shifted word, at the latest in the second word after the slip. This is because every word is compared bit for bit against a position computed from the stream index and the modelled delay. A miscounted rollover point shows as a missing or misplaced `roll_flag`. From then on, every following word is also wrong, because the delay no longer matches. A bad phase counter breaks the `par_tick` spacing within one word period, and edge-detection faults appear when long held requests or short pulses inside a word change the delay.

// File: rtl/bitslip_pkg.sv
package bitslip_pkg;

    localparam int MAX_W    = 10;
    localparam int MIN_W    = 4;
    localparam int MAX_ROLL = 11;
    localparam int WW       = $clog2(MAX_W + 1);
    localparam int CW       = $clog2(MAX_ROLL + 1);

    typedef logic [MAX_W-1:0] word_t;
    typedef logic [WW-1:0]    width_t;
    typedef logic [CW-1:0]    cnt_t;

    // State published by the slip controller at each word boundary.
    typedef struct packed {
        cnt_t delay;
        logic valid;
        logic roll;
    } slip_state_t;

    function automatic width_t clamp_width(width_t w);
        if (w < width_t'(MIN_W)) return width_t'(MIN_W);
        if (w > width_t'(MAX_W)) return width_t'(MAX_W);
        return w;
    endfunction

    function automatic cnt_t clamp_roll(cnt_t r);
        if (r == '0) return cnt_t'(1);
        if (r > cnt_t'(MAX_ROLL)) return cnt_t'(MAX_ROLL);
        return r;
    endfunction

endpackage

// File: rtl/bitslip_delay.sv
module bitslip_delay
    import bitslip_pkg::*;
#(
    parameter int DEPTH = MAX_ROLL
) (
    input  logic clk,
    input  logic rst,
    input  logic ser_in,
    input  cnt_t delay,
    output logic dly_bit
);
    localparam int HW = DEPTH - 1;

    logic [HW-1:0]    hist;
    logic [DEPTH-1:0] taps;

    // tap 0 is the live bit, tap i is the bit from i cycles ago
    assign taps    = {hist, ser_in};
    assign dly_bit = taps[delay];

    always_ff @(posedge clk) begin
        if (rst) hist <= '0;
        else     hist <= taps[HW-1:0];
    end

    p_tap_range_r5: assert property (@(posedge clk) disable iff (rst)
        int'(delay) < DEPTH);

endmodule

// File: rtl/bitslip_shift.sv
module bitslip_shift
    import bitslip_pkg::*;
#(
    parameter int WMAX = MAX_W
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   dly_bit,
    input  width_t width,
    output logic   tick,
    output word_t  word_q,
    output logic   tick_q
);
    logic [WMAX-2:0] sh;
    width_t          phase;
    word_t           mask;
    word_t           word_next;

    generate
        for (genvar i = 0; i < WMAX; i++) begin : g_mask
            assign mask[i] = (i < int'(width));
        end
    endgenerate

    assign tick      = (phase >= width - width_t'(1));
    assign word_next = {sh, dly_bit} & mask;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= '0;
            sh     <= '0;
            word_q <= '0;
            tick_q <= 1'b0;
        end else begin
            sh     <= word_next[WMAX-2:0];
            phase  <= tick ? '0 : phase + width_t'(1);
            tick_q <= tick;
            if (tick) word_q <= word_next;
        end
    end

    p_tick_gap_r1: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);
    p_phase_range_r8: assert property (@(posedge clk) disable iff (rst)
        phase < width);

endmodule

// File: rtl/bitslip_ctrl.sv
module bitslip_ctrl
    import bitslip_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        tick,
    input  logic        slip_req,
    input  cnt_t        roll_pt,
    output slip_state_t st
);
    logic slip_q;
    logic settle;
    logic rise;
    cnt_t cnt_inc;

    assign rise    = slip_req & ~slip_q;
    assign cnt_inc = st.delay + cnt_t'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            slip_q <= 1'b0;
            settle <= 1'b0;
            st     <= '0;
        end else if (tick) begin
            slip_q   <= slip_req;
            settle   <= rise;
            st.valid <= ~settle;
            st.roll  <= rise && (cnt_inc == roll_pt);
            if (rise) st.delay <= (cnt_inc == roll_pt) ? '0 : cnt_inc;
        end
    end

    p_cnt_range_r5: assert property (@(posedge clk) disable iff (rst)
        st.delay < roll_pt);
    p_slip_step_r3: assert property (@(posedge clk) disable iff (rst)
        (st.delay != $past(st.delay)) |-> (st.delay == $past(st.delay) + cnt_t'(1) || st.delay == '0));
    p_roll_wrap_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(st.roll) |-> (st.delay == '0));
    p_hold_between_r4: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(st));

endmodule

// File: rtl/bitslip_deser.sv
module bitslip_deser
    import bitslip_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          ser_in,
    input  logic          slip_req,
    input  logic [WW-1:0] cfg_width,
    input  logic [CW-1:0] cfg_roll,
    output logic [MAX_W-1:0] par_word,
    output logic          par_tick,
    output logic          par_valid,
    output logic          roll_flag
);
    width_t      width_eff;
    cnt_t        roll_eff;
    logic        dly_bit;
    logic        tick;
    slip_state_t st;

    assign width_eff = clamp_width(cfg_width);
    assign roll_eff  = clamp_roll(cfg_roll);

    bitslip_delay #(.DEPTH(MAX_ROLL)) u_delay (
        .clk     (clk),
        .rst     (rst),
        .ser_in  (ser_in),
        .delay   (st.delay),
        .dly_bit (dly_bit)
    );

    bitslip_shift #(.WMAX(MAX_W)) u_shift (
        .clk     (clk),
        .rst     (rst),
        .dly_bit (dly_bit),
        .width   (width_eff),
        .tick    (tick),
        .word_q  (par_word),
        .tick_q  (par_tick)
    );

    bitslip_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .slip_req (slip_req),
        .roll_pt  (roll_eff),
        .st       (st)
    );

    assign par_valid = st.valid;
    assign roll_flag = st.roll;

    p_reset_clear_r7: assert property (@(posedge clk)
        rst |=> (par_word == '0 && !par_valid && !roll_flag && !par_tick));

endmodule

// File: tb/bitslip_deser_test.sv
module bitslip_deser_test;
    localparam int CLK_P = 10;
    localparam int NW    = 72;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ser_in = 1'b0;
    logic       slip_req = 1'b0;
    logic [3:0] cfg_width = 4'd4;
    logic [3:0] cfg_roll = 4'd1;
    logic [9:0] par_word;
    logic       par_tick;
    logic       par_valid;
    logic       roll_flag;

    int checks = 0;
    int errors = 0;
    bit s [0:1023];

    always #(CLK_P/2) clk = ~clk;

    bitslip_deser uut (
        .clk(clk), .rst(rst), .ser_in(ser_in), .slip_req(slip_req),
        .cfg_width(cfg_width), .cfg_roll(cfg_roll),
        .par_word(par_word), .par_tick(par_tick),
        .par_valid(par_valid), .roll_flag(roll_flag)
    );

    function automatic bit lvl(int w, int h, int r);
        int p;
        if (w < 3) return 1'b0;
        p = w - 3;
        if (p / (h + 2) >= r + 2) return 1'b0;
        return (p % (h + 2)) < h;
    endfunction

    function automatic logic [9:0] exp_word(int w, int wd, int d);
        logic [9:0] r = '0;
        for (int j = 0; j < wd; j++) begin
            int idx = (w - 1) * wd + j - d;
            r[wd-1-j] = (idx < 0) ? 1'b0 : s[idx];
        end
        return r;
    endfunction

    task automatic check(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic run_cfg(int wd, int r);
        logic [15:0] lf = 16'hACE1 ^ 16'(wd * 37 + r * 101);
        int h = ((wd + r) % 2 == 1) ? 3 : 1;
        int kb = 0;
        int c = 0;
        for (int i = 0; i < 1024; i++) begin
            s[i] = lf[0];
            lf = {lf[0] ^ lf[2] ^ lf[3] ^ lf[5], lf[15:1]};
        end
        rst = 1'b1; slip_req = 1'b0; ser_in = 1'b0;
        cfg_width = 4'(wd); cfg_roll = 4'(r);
        repeat (3) @(negedge clk);
        // R7: outputs cleared during reset
        check(par_word == '0 && !par_tick && !par_valid && !roll_flag,
              "R7 reset outputs", {par_word, par_tick, par_valid, roll_flag}, 0);
        rst = 1'b0;
        ser_in = s[0];
        slip_req = lvl(1, h, r);
        while (c < NW * wd) begin
            @(negedge clk);
            c++;
            check(par_tick == (c % wd == 0), "R1 par_tick", par_tick, (c % wd == 0));
            if (c % wd == 0) begin
                int w = c / wd;
                bit ev  = lvl(w, h, r) && !lvl(w - 1, h, r);
                bit evp = lvl(w - 1, h, r) && !lvl(w - 2, h, r);
                logic [9:0] ew = exp_word(w, wd, kb);
                // R8: every width/rollover pairing is swept
                check(par_word == ew, (kb > 0) ? "R3 word (R8 sweep)" : "R2 word (R8 sweep)",
                      par_word, ew);
                check(par_valid == !evp, "R6 valid", par_valid, !evp);
                check(roll_flag == (ev && kb + 1 == r), "R5 roll_flag", roll_flag,
                      (ev && kb + 1 == r));
                if (ev) kb = (kb + 1 == r) ? 0 : kb + 1;
            end
            if (c < NW * wd) begin
                int wn  = c / wd + 1;
                int pos = c % wd;
                // R4: short pulses inside a word must not count
                bit gl = (wn % 4 == 2) && (pos < wd - 1) && (pos > 0);
                ser_in = s[c];
                slip_req = lvl(wn, h, r) | (gl && !lvl(wn, h, r));
            end
        end
    endtask

    initial begin
        #(CLK_P * 150000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int wd = 4; wd <= 10; wd++)
            for (int r = 1; r <= 11; r++)
                run_cfg(wd, r);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule